// File: doc/BRIEF.md
# Two-Master Priority Bus Arbiter

This block decides which of two requesters owns a shared on-chip bus: a processor core, or a group of DMA channels that reaches the arbiter as one combined request. A programmable priority bit picks which of the two wins when both are waiting. A second bit switches arbitration off. The core then holds the bus for good, and DMA is never granted.

The arbiter decides only at bus-cycle boundaries. It follows the bus through a start strobe and an end strobe. A master that holds the grant keeps it until its current bus cycle ends. The core raises a killed-fetch strobe when an instruction fetch stops early because it hit in the cache. When it does, the arbiter treats the core as the lower-priority master for its next decision. A waiting DMA request can then use the slot the core would have left empty. This is the only fairness the arbiter has. Otherwise a steady stream of requests from the higher-priority master starves the other one.

Top module: `arb2_bus_arbiter`

## Requirements
- R1: Synchronous reset clears both control bits (core-first, arbitration on) and gives the grant to the core on the first edge with `rst` high.
- R2: Exactly one of `core_gnt` and `dma_gnt` is high in every cycle.
- R3: With the priority bit at 0 and no demotion pending, a decision with both requesting grants the core.
- R4: With the priority bit at 1, a decision with both requesting grants DMA.
- R5: With the disable bit at 1, every decision grants the core, whatever `dma_req` does.
- R6: A decision point is a cycle with `cyc_end` high, or an idle cycle with no `cyc_start`. The grant changes only on the edge that ends a decision point, so it is held from `cyc_start` through the cycle with `cyc_end`.
- R7: A decision with no request pending parks the grant on the core.
- R8: A `fetch_killed` pulse demotes the core for the next decision that has a request pending. DMA wins that decision even with the priority bit at 0. The demotion is then consumed, and the decision after it is core-first again.
- R9: A `cfg_wr` pulse loads `cfg_dma_first_in` and `cfg_arb_off_in` on that edge. The new values act from the next decision point on, and the grant of a bus cycle in progress does not change.
- R10: A single requester wins a decision regardless of the priority bit, except that DMA never wins while arbitration is disabled.
- R11: No fairness is added. With the priority bit at 0, the core requesting continuously and no killed fetches, DMA stays ungranted across any number of core bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load strobe for the two control bits |
| cfg_dma_first_in | input | 1 | Priority bit: 0 core first, 1 DMA first |
| cfg_arb_off_in | input | 1 | Disable bit: 1 turns arbitration off |
| core_req | input | 1 | Core requests the bus |
| dma_req | input | 1 | Combined DMA channel request |
| cyc_start | input | 1 | First cycle of a bus cycle |
| cyc_end | input | 1 | Last cycle of a bus cycle |
| fetch_killed | input | 1 | Core fetch ended early on a cache hit |
| core_gnt | output | 1 | Bus granted to the core |
| dma_gnt | output | 1 | Bus granted to DMA |

## Verification
The bench targets these corner cases:
- A killed fetch that arrives in the same cycle as `cyc_end`. An arbiter that registers the strobe one cycle late gives the core one more cycle.
- A demotion that should be spent on one decision only. Keeping it would hand DMA a second cycle.
- A control write in the middle of a bus cycle. A design that arbitrates on every clock would drop the grant mid-cycle.
- Single-cycle bus cycles, where `cyc_start` and `cyc_end` coincide.
- The disable bit set while DMA keeps requesting.

A behavioural model follows the decisions every cycle, and any wrong owner shows up as a mismatch in that cycle.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
   localparam int unsigned MST_N   = 2;
   localparam int unsigned CORE_IX = 0;
   localparam int unsigned DMA_IX  = 1;

   typedef logic [MST_N-1:0] gnt_t;

   typedef struct packed {
      logic dma_first;
      logic arb_off;
   } ctl_t;

   localparam gnt_t GNT_CORE = gnt_t'(1) << CORE_IX;
   localparam gnt_t GNT_DMA  = gnt_t'(1) << DMA_IX;
endpackage

// File: rtl/arb2_ctl_reg.sv
module arb2_ctl_reg
   import arb2_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic wr,
   input  ctl_t ctl_in,
   output ctl_t ctl_q
);
   always_ff @(posedge clk) begin
      if (rst)     ctl_q <= '0;
      else if (wr) ctl_q <= ctl_in;
   end

   a_r1_ctl_clear: assert property (@(posedge clk) rst |=> (ctl_q == '0));
endmodule

// File: rtl/arb2_cyc_track.sv
module arb2_cyc_track (
   input  logic clk,
   input  logic rst,
   input  logic cyc_start,
   input  logic cyc_end,
   output logic busy_q,
   output logic arb_pt
);
   always_ff @(posedge clk) begin
      if (rst)            busy_q <= 1'b0;
      else if (cyc_end)   busy_q <= 1'b0;
      else if (cyc_start) busy_q <= 1'b1;
   end

   assign arb_pt = cyc_end | (~busy_q & ~cyc_start);

   a_r6_busy_tracks: assert property (@(posedge clk) disable iff (rst)
      (cyc_start && !cyc_end) |=> busy_q);
endmodule

// File: rtl/arb2_demote.sv
module arb2_demote (
   input  logic clk,
   input  logic rst,
   input  logic fetch_killed,
   input  logic arb_pt,
   input  logic any_req,
   output logic demote_eff
);
   logic dem_q;
   logic consume;

   assign consume    = arb_pt & any_req;
   assign demote_eff = dem_q | fetch_killed;

   always_ff @(posedge clk) begin
      if (rst)          dem_q <= 1'b0;
      else if (consume) dem_q <= 1'b0;
      else              dem_q <= demote_eff;
   end

   a_r8_spent_once: assert property (@(posedge clk) disable iff (rst)
      consume |=> !dem_q);
   a_r8_held: assert property (@(posedge clk) disable iff (rst)
      (fetch_killed && !consume) |=> dem_q);
endmodule

// File: rtl/arb2_pick.sv
module arb2_pick
   import arb2_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic arb_pt,
   input  ctl_t ctl,
   input  logic demote,
   input  logic core_req,
   input  logic dma_req,
   output gnt_t gnt_q
);
   logic dma_wins;
   gnt_t gnt_d;

   always_comb begin
      dma_wins = ~ctl.arb_off & dma_req & (~core_req | ctl.dma_first | demote);
      gnt_d    = dma_wins ? GNT_DMA : GNT_CORE;
   end

   always_ff @(posedge clk) begin
      if (rst)         gnt_q <= GNT_CORE;
      else if (arb_pt) gnt_q <= gnt_d;
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot(gnt_q));
   a_r5_off_core: assert property (@(posedge clk) disable iff (rst)
      (arb_pt && ctl.arb_off) |=> gnt_q[CORE_IX]);
   a_r7_park: assert property (@(posedge clk) disable iff (rst)
      (arb_pt && !core_req && !dma_req) |=> gnt_q[CORE_IX]);
   a_r4_dma_first: assert property (@(posedge clk) disable iff (rst)
      (arb_pt && !ctl.arb_off && ctl.dma_first && dma_req) |=> gnt_q[DMA_IX]);
   a_r3_core_first: assert property (@(posedge clk) disable iff (rst)
      (arb_pt && !ctl.dma_first && !demote && core_req) |=> gnt_q[CORE_IX]);
endmodule

// File: rtl/arb2_bus_arbiter.sv
module arb2_bus_arbiter
   import arb2_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cfg_wr,
   input  logic cfg_dma_first_in,
   input  logic cfg_arb_off_in,
   input  logic core_req,
   input  logic dma_req,
   input  logic cyc_start,
   input  logic cyc_end,
   input  logic fetch_killed,
   output logic core_gnt,
   output logic dma_gnt
);
   initial begin
      if (MST_N != 2) $error("arb2_bus_arbiter supports exactly two masters");
      if (CORE_IX == DMA_IX) $error("master indices must differ");
   end

   ctl_t ctl_in, ctl_q;
   logic busy_q, arb_pt, demote;
   gnt_t gnt_q;

   assign ctl_in.dma_first = cfg_dma_first_in;
   assign ctl_in.arb_off   = cfg_arb_off_in;

   arb2_ctl_reg u_ctl (
      .clk(clk), .rst(rst), .wr(cfg_wr), .ctl_in(ctl_in), .ctl_q(ctl_q)
   );

   arb2_cyc_track u_trk (
      .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
      .busy_q(busy_q), .arb_pt(arb_pt)
   );

   arb2_demote u_dem (
      .clk(clk), .rst(rst), .fetch_killed(fetch_killed), .arb_pt(arb_pt),
      .any_req(core_req | dma_req), .demote_eff(demote)
   );

   arb2_pick u_pick (
      .clk(clk), .rst(rst), .arb_pt(arb_pt), .ctl(ctl_q), .demote(demote),
      .core_req(core_req), .dma_req(dma_req), .gnt_q(gnt_q)
   );

   assign core_gnt = gnt_q[CORE_IX];
   assign dma_gnt  = gnt_q[DMA_IX];

   a_r1_reset_core: assert property (@(posedge clk) rst |=> (core_gnt && !dma_gnt));
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !cyc_end) |=> ($stable(core_gnt) && $stable(dma_gnt)));
endmodule

// File: tb/test_arb2_bus_arbiter.sv
module test_arb2_bus_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_wr = 0, cfg_dma_first_in = 0, cfg_arb_off_in = 0;
   logic core_req = 0, dma_req = 0, cyc_start = 0, cyc_end = 0, fetch_killed = 0;
   logic core_gnt, dma_gnt;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   arb2_bus_arbiter i_arb2_bus_arbiter (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dma_first_in(cfg_dma_first_in),
      .cfg_arb_off_in(cfg_arb_off_in), .core_req(core_req), .dma_req(dma_req),
      .cyc_start(cyc_start), .cyc_end(cyc_end), .fetch_killed(fetch_killed),
      .core_gnt(core_gnt), .dma_gnt(dma_gnt)
   );

   // behavioural reference: owner 0 = core, 1 = dma
   int m_owner = 0;
   bit m_busy = 0, m_dem = 0, m_dmaf = 0, m_off = 0;

   always @(posedge clk) begin
      bit decide, first, nb, nd;
      int no;
      if (rst) begin
         m_owner = 0; m_busy = 0; m_dem = 0; m_dmaf = 0; m_off = 0;
      end else begin
         decide = cyc_end || (!m_busy && !cyc_start);
         first  = m_dmaf || m_dem || fetch_killed;
         no = m_owner;
         if (decide) begin
            if (m_off) no = 0;
            else if (dma_req && (!core_req || first)) no = 1;
            else no = 0;
         end
         nd = (decide && (core_req || dma_req)) ? 1'b0 : (m_dem || fetch_killed);
         nb = cyc_end ? 1'b0 : (cyc_start ? 1'b1 : m_busy);
         if (cfg_wr) begin m_dmaf = cfg_dma_first_in; m_off = cfg_arb_off_in; end
         m_owner = no; m_dem = nd; m_busy = nb;
      end
   end

   task automatic check(string req, logic got, logic exp, string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
      end
   endtask

   // R2 and scenario tag: compare to model every cycle, away from the edge
   always @(negedge clk) begin
      if (!rst) begin
         check("R2", core_gnt ^ dma_gnt, 1'b1, "one-hot grant");
         check(cur_req, dma_gnt, (m_owner == 1), "model dma_gnt");
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   // one bus cycle of len clocks; kill asserts fetch_killed with the end strobe
   task automatic bus(int len, bit kill = 0);
      cyc_start = 1; cyc_end = (len == 1); fetch_killed = kill && (len == 1);
      tick();
      cyc_start = 0; cyc_end = 0; fetch_killed = 0;
      if (len > 1) begin
         tick(len - 2);
         cyc_end = 1; fetch_killed = kill;
         tick();
         cyc_end = 0; fetch_killed = 0;
      end
   endtask

   task automatic cfg(bit dmaf, bit off);
      cfg_wr = 1; cfg_dma_first_in = dmaf; cfg_arb_off_in = off;
      tick();
      cfg_wr = 0;
   endtask

   initial begin
      int wd = 0;
      while (wd < WATCHDOG) begin @(posedge clk); wd++; end
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<%0d cycles", wd, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      check("R1", core_gnt, 1'b1, "reset core_gnt");
      check("R1", dma_gnt, 1'b0, "reset dma_gnt");
      rst = 0;
      // R1: control cleared means core first
      cur_req = "R1"; core_req = 1; dma_req = 1; tick();
      check("R1", core_gnt, 1'b1, "core-first after reset");
      // R7 park
      cur_req = "R7"; core_req = 0; dma_req = 0; tick(2);
      check("R7", core_gnt, 1'b1, "park on core");
      // R10 lone dma
      cur_req = "R10"; dma_req = 1; tick();
      check("R10", dma_gnt, 1'b1, "lone dma wins");
      bus(3); dma_req = 0; tick();
      check("R7", core_gnt, 1'b1, "park after dma");
      // R3/R11 starvation
      cur_req = "R11"; core_req = 1; dma_req = 1; tick();
      for (int i = 0; i < 6; i++) bus(2 + (i % 3));
      check("R11", dma_gnt, 1'b0, "dma starved");
      check("R3", core_gnt, 1'b1, "core first with both");
      // R8 demotion on killed fetch at cycle end
      cur_req = "R8"; bus(2, 1);
      check("R8", dma_gnt, 1'b1, "demoted core loses");
      bus(2);
      check("R8", core_gnt, 1'b1, "demotion spent once");
      bus(1, 1);
      check("R8", dma_gnt, 1'b1, "single-cycle kill demotes");
      bus(1);
      check("R8", core_gnt, 1'b1, "back to core");
      // R9 write mid-cycle
      cur_req = "R9"; cyc_start = 1; tick(); cyc_start = 0;
      cfg(1, 0); tick();
      check("R9", core_gnt, 1'b1, "grant held during write");
      cyc_end = 1; tick(); cyc_end = 0;
      check("R4", dma_gnt, 1'b1, "dma first after write");
      cur_req = "R4"; bus(2); bus(1);
      check("R4", dma_gnt, 1'b1, "dma keeps winning");
      // R5 disable
      cur_req = "R5"; cfg(1, 1); bus(2); tick(2);
      check("R5", core_gnt, 1'b1, "disabled: core");
      core_req = 0; tick(2);
      check("R5", dma_gnt, 1'b0, "disabled: lone dma refused");
      // R6 mixed traffic against model
      cur_req = "R6"; cfg(0, 0); core_req = 1;
      for (int i = 0; i < 200; i++) begin
         core_req = (i % 5) != 0; dma_req = (i % 3) != 1;
         if (i % 7 == 3) cfg((i % 2) == 1, (i % 11) == 3);
         bus(1 + (i % 4), (i % 6) == 2);
         if (i % 4 == 0) tick();
      end
      // R1 reset mid-run
      cur_req = "R1"; rst = 1; tick(); rst = 0;
      check("R1", core_gnt, 1'b1, "reset mid-run");
      tick(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule